// File: doc/BRIEF.md
# Synchronous Burst SRAM with Beat Counter

A single-port static memory in which every input is sampled on the rising clock edge. A requester issues a burst by pulsing the start input with a base address, a direction and an order select. The block then produces the next three addresses itself. Each beat after the first is stepped by the advance input, so the requester drives the address only once per four-word transfer.

Two orders are available, and the order is captured together with the start. The linear order counts the two low address bits upward and wraps around. The interleaved order XORs the beat number into the base address. The upper address bits keep their captured value for the whole burst. A build parameter selects the read path. The flow-through path shows the array word in the cycle after the selecting edge. The pipelined path adds one output register, which gives one extra clock of first-word latency and then one word per clock.

The data bus is shared between reads and writes. When a write burst is requested while read data is on the bus, the block spends one cycle turning the bus around. During that cycle it flags the turnaround, and any advance presented in that cycle is discarded.

Top module: `sync_burst_sram`

## Requirements
- R1: The base address, direction and order are taken from the inputs at the edge where `start_i` is high. Later changes on `addr_i`, `we_i` or `order_i` have no effect on a burst that is already running.
- R2: A burst has exactly four beats. After the fourth advance the burst ends and `rvalid_o` drops.
- R3: With `order_i`=0 (linear), the beat k address keeps the base's upper bits. Its low two bits are (base[1:0]+k) mod 4. A base ending in 1 gives 1,2,3,0.
- R4: With `order_i`=1 (interleaved), the beat k low bits are base[1:0] XOR k. A base ending in 1 gives 1,0,3,2.
- R5: The beat counter moves only at an edge where `adv_i` is high. Without that, the current beat and its read word stay in place.
- R6: `start_i` reloads the counter at any time, including in the middle of a burst. It takes priority over `adv_i` in the same cycle.
- R7: In a write burst, each advance edge stores `wdata_i` at the current beat address.
- R8: With PIPELINE=0, a read beat's word is on `rdata_o` with `rvalid_o` high in the cycle after the edge that selected the beat. With PIPELINE=1 it appears one cycle later. When `rvalid_o` is low, `rdata_o` is zero.
- R9: A write start at an edge where `rvalid_o` is high raises `turn_o` for exactly one cycle. An advance during that cycle neither writes nor moves the counter. A write start at any other edge leaves `turn_o` low.
- R10: After reset, no burst is active, and `rvalid_o`, `turn_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst at `addr_i` |
| adv_i | input | 1 | Step to the next beat |
| we_i | input | 1 | Burst direction: 1 write, 0 read (sampled with start) |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved (sampled with start) |
| addr_i | input | ADDR_W | Burst base address |
| wdata_i | input | DATA_W | Write word, stored on an advance edge |
| rdata_o | output | DATA_W | Read word, zero when not valid |
| rvalid_o | output | 1 | Read word on the bus |
| turn_o | output | 1 | Bus turnaround cycle in progress |

## Verification
The bench builds two copies of the block with the default 64-word by 8-bit array. One has PIPELINE=0 and the other PIPELINE=1, and both are driven by the same stimulus. Every read beat is therefore checked on the same clock edge against both latencies, and the turnaround rule is checked against both bus-occupancy timings. This matters because in the pipelined copy read data stays on the bus one cycle longer after the final advance. Write and read orders are mixed across bursts, so the sets of addresses the two orders visit are compared against each other.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // low two address bits of beat number cnt
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input burst_order_e ord);
        if (ord == ORD_INTERLEAVE) return base ^ cnt;
        return base + cnt;
    endfunction

endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic              we_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bus_read_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              rd_beat_o,
    output logic              wr_en_o,
    output logic              turn_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        burst_order_e      ord;
        logic              active;
        logic              wr;
        logic              turn;
    } ctr_t;

    ctr_t st_d, st_q;
    logic step;

    always_comb begin
        st_d      = st_q;
        st_d.turn = 1'b0;
        step      = st_q.active && !st_q.turn && adv_i && !start_i;
        if (start_i) begin
            st_d.base   = addr_i;
            st_d.cnt    = 2'd0;
            st_d.ord    = burst_order_e'(order_i);
            st_d.active = 1'b1;
            st_d.wr     = we_i;
            st_d.turn   = we_i && bus_read_i;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 2'd1;
            if (st_q.cnt == 2'd3) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ctr_t'('0);
        else        st_q <= st_d;
    end

    assign cur_addr_o = {st_q.base[ADDR_W-1:2], beat_low(st_q.base[1:0], st_q.cnt, st_q.ord)};
    assign rd_beat_o  = st_q.active && !st_q.wr;
    assign wr_en_o    = step && st_q.wr;
    assign turn_o     = st_q.turn;

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
    parameter int DATA_W   = 8,
    parameter bit PIPELINE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    generate
        if (PIPELINE) begin : g_pipe
            typedef struct packed {
                logic              valid;
                logic [DATA_W-1:0] data;
            } out_t;

            out_t out_d, out_q;

            always_comb begin
                out_d.valid = valid_i;
                out_d.data  = valid_i ? data_i : '0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end

            assign valid_o = out_q.valid;
            assign data_o  = out_q.data;
        end else begin : g_flow
            assign valid_o = valid_i;
            assign data_o  = valid_i ? data_i : '0;
        end
    endgenerate

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter bit PIPELINE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              adv_i,
    input  logic              we_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              turn_o
);

    logic [ADDR_W-1:0] cur_addr;
    logic              rd_beat;
    logic              wr_en;
    logic [DATA_W-1:0] arr_rdata;

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .adv_i      (adv_i),
        .we_i       (we_i),
        .order_i    (order_i),
        .addr_i     (addr_i),
        .bus_read_i (rvalid_o),
        .cur_addr_o (cur_addr),
        .rd_beat_o  (rd_beat),
        .wr_en_o    (wr_en),
        .turn_o     (turn_o)
    );

    sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .addr  (cur_addr),
        .wdata (wdata_i),
        .rdata (arr_rdata)
    );

    sbs_out_stage #(.DATA_W(DATA_W), .PIPELINE(PIPELINE)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (rd_beat),
        .data_i  (arr_rdata),
        .valid_o (rvalid_o),
        .data_o  (rdata_o)
    );

endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
    parameter int DATA_W   = 8,
    parameter bit PIPELINE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              we_i,
    input logic              rvalid_o,
    input logic              turn_o,
    input logic [DATA_W-1:0] rdata_o
);

    // R9
    turn_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && we_i && rvalid_o) |=> turn_o);

    // R9
    no_spurious_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i || !we_i || !rvalid_o) |=> !turn_o);

    // R9
    turn_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_o |=> !turn_o);

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    generate
        if (PIPELINE) begin : g_pipe_chk
            // R8
            first_word_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (start_i && !we_i) |=> ##1 rvalid_o);
        end else begin : g_flow_chk
            // R8
            first_word_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (start_i && !we_i) |=> rvalid_o);
        end
    endgenerate

endmodule

bind sync_burst_sram sbs_sram_chk #(.DATA_W(DATA_W), .PIPELINE(PIPELINE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .we_i     (we_i),
    .rvalid_o (rvalid_o),
    .turn_o   (turn_o),
    .rdata_o  (rdata_o)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;

    // {base[5:0], write order, read order, data seed[7:0]}
    localparam logic [15:0] VEC [6] = '{
        {6'h01, 1'b0, 1'b0, 8'h10},
        {6'h05, 1'b1, 1'b1, 8'h40},
        {6'h3E, 1'b0, 1'b1, 8'h70},
        {6'h13, 1'b1, 1'b0, 8'hA0},
        {6'h22, 1'b0, 1'b0, 8'hC3},
        {6'h08, 1'b1, 1'b1, 8'h5A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, adv = 1'b0, we = 1'b0, ord = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] f_rdata, p_rdata;
    logic f_rvalid, p_rvalid, f_turn, p_turn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] mdl [1 << AW];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINE(1'b0)) i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .start_i(start), .adv_i(adv), .we_i(we),
        .order_i(ord), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(f_rdata), .rvalid_o(f_rvalid), .turn_o(f_turn));

    sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .PIPELINE(1'b1)) i_sync_burst_sram_p (
        .clk(clk), .rst_n(rst_n), .start_i(start), .adv_i(adv), .we_i(we),
        .order_i(ord), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(p_rdata), .rvalid_o(p_rvalid), .turn_o(p_turn));

    function automatic logic [AW-1:0] ea(input logic [AW-1:0] b, input logic o, input int k);
        logic [1:0] kk;
        kk = 2'(k);
        if (o) return {b[AW-1:2], b[1:0] ^ kk};
        return {b[AW-1:2], 2'(b[1:0] + kk)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic a, input logic w,
                       input logic [AW-1:0] ad, input logic [DW-1:0] wd, input logic o);
        start = s; adv = a; we = w; addr = ad; wdata = wd; ord = o;
        @(posedge clk);
        #1;
        start = 1'b0; adv = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic write_burst(input logic [AW-1:0] b, input logic o, input logic [DW-1:0] seed);
        cyc(1'b1, 1'b0, 1'b1, b, '0, o);
        chk(!f_turn && !p_turn, "R9 no turn after idle", {7'b0, f_turn | p_turn}, 8'h0);
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] d;
            d = seed + 8'(k * 17);
            mdl[ea(b, o, k)] = d;
            // R1: address/order inputs scrambled during beats
            cyc(1'b0, 1'b1, 1'b0, ~b, d, ~o);
        end
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic read_burst(input logic [AW-1:0] b, input logic o);
        logic [DW-1:0] e;
        cyc(1'b1, 1'b0, 1'b0, b, '0, o);
        e = mdl[ea(b, o, 0)];
        chk(f_rvalid && f_rdata == e, "R8 R3 R4 flow beat0", f_rdata, e);
        chk(!p_rvalid, "R8 pipe latency", {7'b0, p_rvalid}, 8'h0);
        for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 1'b1, 1'b1, ~b, 8'hFF, ~o);
            e = mdl[ea(b, o, k)];
            chk(p_rvalid && p_rdata == e, "R8 R3 R4 pipe beat", p_rdata, e);
            if (k < 3) begin
                e = mdl[ea(b, o, k + 1)];
                chk(f_rvalid && f_rdata == e, "R3 R4 R7 flow beat", f_rdata, e);
            end else begin
                chk(!f_rvalid && f_rdata == '0, "R2 burst ends", f_rdata, 8'h0);
            end
        end
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
        chk(!p_rvalid, "R2 pipe burst ends", {7'b0, p_rvalid}, 8'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R10
        chk(!f_rvalid && !p_rvalid && !f_turn && !p_turn, "R10 reset flags",
            {4'b0, f_rvalid, p_rvalid, f_turn, p_turn}, 8'h0);
        chk(f_rdata == '0 && p_rdata == '0, "R10 reset data", f_rdata | p_rdata, 8'h0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        chk(!f_rvalid && !p_rvalid, "R10 no burst active", {7'b0, f_rvalid | p_rvalid}, 8'h0);

        // vector table: write then read every burst
        for (int v = 0; v < 6; v++) begin
            write_burst(VEC[v][15:10], VEC[v][9], VEC[v][7:0]);
            read_burst(VEC[v][15:10], VEC[v][8]);
        end

        // R5: no advance keeps the beat
        cyc(1'b1, 1'b0, 1'b0, 6'h01, '0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
        chk(f_rdata == mdl[6'h01], "R5 flow hold", f_rdata, mdl[6'h01]);
        chk(p_rdata == mdl[6'h01], "R5 pipe hold", p_rdata, mdl[6'h01]);
        cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        chk(f_rdata == mdl[6'h02], "R5 step after hold", f_rdata, mdl[6'h02]);

        // R6: start with adv mid-burst reloads, start wins
        cyc(1'b1, 1'b1, 1'b0, 6'h3E, '0, 1'b0);
        chk(f_rdata == mdl[6'h3E], "R6 reload beat0", f_rdata, mdl[6'h3E]);
        cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        chk(f_rdata == mdl[6'h3F], "R6 R3 after reload", f_rdata, mdl[6'h3F]);
        cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        chk(f_rdata == mdl[6'h3C], "R3 upper bits kept on wrap", f_rdata, mdl[6'h3C]);

        // R9: write start while read on the bus
        cyc(1'b1, 1'b0, 1'b1, 6'h30, '0, 1'b0);
        chk(f_turn && p_turn, "R9 turn raised", {6'b0, f_turn, p_turn}, 8'h3);
        cyc(1'b0, 1'b1, 1'b0, '0, 8'hEE, 1'b0);
        chk(!f_turn && !p_turn, "R9 turn one cycle", {6'b0, f_turn, p_turn}, 8'h0);
        for (int k = 0; k < 4; k++) begin
            mdl[6'h30 + k] = 8'hD0 + 8'(k);
            cyc(1'b0, 1'b1, 1'b0, '0, 8'hD0 + 8'(k), 1'b0);
        end
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 6'h30, '0, 1'b0);
        chk(f_rdata == 8'hD0, "R9 R7 adv ignored in turn", f_rdata, 8'hD0);
        cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
        chk(f_rdata == 8'hD1, "R7 second write beat", f_rdata, 8'hD1);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);

        finish_run();
    end

endmodule